// File: doc/BRIEF.md
# Banked Data Address Generator

This block forms the 12-bit data memory address used by byte- and bit-oriented operations. The data space holds 4096 bytes split into sixteen 256-byte banks. From an 8-bit file field, an access-select bit, a 4-bit bank register, a 12-bit base pointer and an extended-mode enable, the block picks one of three ways to build the address. A fourth path passes a complete 12-bit operand straight through for move operations that carry both addresses in full.

Alongside the address, the block reports which path it used as a 2-bit mode code. The address can be taken straight from the logic or through one output register, chosen by a parameter. The default build registers the output, so the address and mode appear one clock after the inputs. Decoding the operation, the memory array, pointer side-effects and the ALU are outside this block.

Top module: `dag_addr_gen`

## Requirements
- R1: With the full-address flag low and the access bit high, the address is the bank register in bits 11:8 and the file field in bits 7:0, for every file value and in both extended states; mode is 01.
- R2: With the full-address flag low, the access bit low and extended mode off, file values 00h-5Fh give addresses 000h-05Fh, and file values 60h-FFh give F60h-FFFh; mode is 00.
- R3: With the full-address flag low, the access bit low, extended mode on and a file value of 5Fh or less, the address is the base pointer plus the zero-extended file value, taken modulo 4096; mode is 10.
- R4: With the full-address flag low, the access bit low, extended mode on and a file value of 60h or more, the address is F00h plus the file value, as in R2; mode is 00.
- R5: With the full-address flag high, the address is the 12-bit full operand and mode is 11, whatever the bank register, access bit, extended enable, pointer and file field hold.
- R6: With the output register enabled (the default), address and mode show the inputs sampled at the previous rising clock edge.
- R7: While rst_n is low at a rising edge, the registered address becomes 000h and the mode becomes 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| file_i | input | 8 | File field of the operation |
| acc_i | input | 1 | Access select: 1 uses the bank register, 0 uses the access bank |
| bsr_i | input | 4 | Bank register value |
| ptr2_i | input | 12 | Base pointer used in indexed mode |
| ext_en_i | input | 1 | Extended addressing enable |
| full_en_i | input | 1 | Operation carries a complete 12-bit address |
| full_addr_i | input | 12 | Complete address used when full_en_i is high |
| addr_o | output | 12 | Target data address |
| mode_o | output | 2 | Mode: 00 forced, 01 bank, 10 indexed, 11 full |

## Verification
The hardest cases to reach are the edges of the access-bank split, meaning file values 5Fh and 60h with extended mode both on and off, and an indexed sum that carries past FFFh. To hit them, the stimulus sweeps all 256 file values for every combination of access bit and extended enable. During the extended sweep the base pointer is held close to the top of memory, so the upper part of the indexed range wraps to low addresses. A separate sweep with the full-address flag high keeps changing the bank, access, extended and file inputs, which shows that none of them reach the result.

// File: rtl/dag_pkg.sv
// Package: shared widths and the mode code for the data address generator.
// Assumes a 4096-byte data space of 16 banks x 256 bytes.
package dag_pkg;
    localparam int ADDR_W = 12;
    localparam int FILE_W = 8;
    localparam int BANK_W = ADDR_W - FILE_W;

    typedef enum logic [1:0] {
        MODE_FORCED  = 2'b00,
        MODE_BANK    = 2'b01,
        MODE_INDEXED = 2'b10,
        MODE_FULL    = 2'b11
    } dag_mode_e;
endpackage

// File: rtl/dag_access_map.sv
// Access-bank mapper: turns a file value into a bottom-of-bank-0 address
// below the split point, or a top-bank address at and above it.
// Assumes SPLIT lies inside the file range.
module dag_access_map #(
    parameter int ADDR_W = 12,
    parameter int FILE_W = 8,
    parameter int SPLIT  = 'h60
) (
    input  logic [FILE_W-1:0] file_i,
    output logic              low_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HI_W = ADDR_W - FILE_W;

    // Pick the bank page from which side of the split the file lies on.
    always_comb begin
        low_o  = (int'(file_i) < SPLIT);
        addr_o = {(low_o ? {HI_W{1'b0}} : {HI_W{1'b1}}), file_i};
    end

    // R2 / R4: a forced address always sits in the bottom or top bank.
    always_comb begin
        a_r2_forced_page: assert (addr_o[FILE_W-1:0] == file_i &&
            (addr_o[ADDR_W-1:FILE_W] == '0 || addr_o[ADDR_W-1:FILE_W] == '1))
            else $error("forced address outside bottom/top bank");
    end
endmodule

// File: rtl/dag_index_add.sv
// Indexed adder: base pointer plus zero-extended file offset, wrapping
// modulo the size of the data space. Purely combinational.
module dag_index_add #(
    parameter int ADDR_W = 12,
    parameter int FILE_W = 8
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [FILE_W-1:0] off_i,
    output logic [ADDR_W-1:0] sum_o
);
    // Add with the carry out of the top bit dropped.
    always_comb begin
        sum_o = ptr_i + {{(ADDR_W-FILE_W){1'b0}}, off_i};
    end
endmodule

// File: rtl/dag_mode_sel.sv
// Mode selector: chooses between full, bank, indexed and forced paths in
// that priority order and reports the chosen mode.
module dag_mode_sel
    import dag_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int FILE_W = 8
) (
    input  logic [FILE_W-1:0]        file_i,
    input  logic                     acc_i,
    input  logic [ADDR_W-FILE_W-1:0] bsr_i,
    input  logic                     ext_en_i,
    input  logic                     full_en_i,
    input  logic [ADDR_W-1:0]        full_addr_i,
    input  logic                     file_low_i,
    input  logic [ADDR_W-1:0]        forced_addr_i,
    input  logic [ADDR_W-1:0]        index_addr_i,
    output logic [ADDR_W-1:0]        addr_o,
    output dag_mode_e                mode_o
);
    // Priority select of the address source.
    always_comb begin
        if (full_en_i) begin
            mode_o = MODE_FULL;
            addr_o = full_addr_i;
        end else if (acc_i) begin
            mode_o = MODE_BANK;
            addr_o = {bsr_i, file_i};
        end else if (ext_en_i && file_low_i) begin
            mode_o = MODE_INDEXED;
            addr_o = index_addr_i;
        end else begin
            mode_o = MODE_FORCED;
            addr_o = forced_addr_i;
        end
    end

    // R5: the full path wins over every other select.
    always_comb begin
        a_r5_full_priority: assert (!full_en_i || mode_o == MODE_FULL)
            else $error("full flag did not select full mode");
    end
endmodule

// File: rtl/dag_addr_gen.sv
// Top: banked data address generator. Builds the 12-bit target address
// and mode code; REG_OUT=1 adds one output register with synchronous
// active-low reset, REG_OUT=0 makes the outputs combinational.
module dag_addr_gen
    import dag_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int FILE_W  = 8,
    parameter int SPLIT   = 'h60,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [FILE_W-1:0]        file_i,
    input  logic                     acc_i,
    input  logic [ADDR_W-FILE_W-1:0] bsr_i,
    input  logic [ADDR_W-1:0]        ptr2_i,
    input  logic                     ext_en_i,
    input  logic                     full_en_i,
    input  logic [ADDR_W-1:0]        full_addr_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [1:0]               mode_o
);
    logic              file_low;
    logic [ADDR_W-1:0] forced_addr;
    logic [ADDR_W-1:0] index_addr;
    logic [ADDR_W-1:0] next_addr;
    dag_mode_e         next_mode;

    dag_access_map #(.ADDR_W(ADDR_W), .FILE_W(FILE_W), .SPLIT(SPLIT)) u_map (
        .file_i (file_i),
        .low_o  (file_low),
        .addr_o (forced_addr)
    );

    dag_index_add #(.ADDR_W(ADDR_W), .FILE_W(FILE_W)) u_add (
        .ptr_i (ptr2_i),
        .off_i (file_i),
        .sum_o (index_addr)
    );

    dag_mode_sel #(.ADDR_W(ADDR_W), .FILE_W(FILE_W)) u_sel (
        .file_i        (file_i),
        .acc_i         (acc_i),
        .bsr_i         (bsr_i),
        .ext_en_i      (ext_en_i),
        .full_en_i     (full_en_i),
        .full_addr_i   (full_addr_i),
        .file_low_i    (file_low),
        .forced_addr_i (forced_addr),
        .index_addr_i  (index_addr),
        .addr_o        (next_addr),
        .mode_o        (next_mode)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [ADDR_W-1:0] addr_q;
            logic [1:0]        mode_q;

            // Output register, cleared by synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q <= '0;
                    mode_q <= MODE_FORCED;
                end else begin
                    addr_q <= next_addr;
                    mode_q <= next_mode;
                end
            end

            // Drive the ports from the register.
            always_comb begin
                addr_o = addr_q;
                mode_o = mode_q;
            end

            // R1: bank path places the bank register above the file field.
            a_r1_bank_concat: assert property (@(posedge clk) disable iff (!rst_n)
                (!full_en_i && acc_i) |=> (addr_o == {$past(bsr_i), $past(file_i)}
                                          && mode_o == MODE_BANK))
                else $error("bank address wrong");

            // R3: indexed path adds the offset to the pointer with wrap.
            a_r3_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (!full_en_i && !acc_i && ext_en_i && int'(file_i) < SPLIT) |=>
                (mode_o == MODE_INDEXED &&
                 addr_o == ADDR_W'($past(ptr2_i) + ADDR_W'($past(file_i)))))
                else $error("indexed address wrong");

            // R5: full operand passes through unchanged.
            a_r5_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
                full_en_i |=> (addr_o == $past(full_addr_i) && mode_o == MODE_FULL))
                else $error("full address not passed");

            // R7: reset leaves the output at zero in forced mode.
            a_r7_reset_clear: assert property (@(posedge clk)
                !rst_n |=> (addr_o == '0 && mode_o == MODE_FORCED))
                else $error("reset did not clear output");
        end else begin : g_comb
            // Combinational outputs.
            always_comb begin
                addr_o = next_addr;
                mode_o = next_mode;
            end
        end
    endgenerate
endmodule

// File: tb/tb_dag_addr_gen.sv
// Bench: behavioural model with an expectation queue, compared each clock.
module tb_dag_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  file_i = '0;
    logic        acc_i = 1'b0;
    logic [3:0]  bsr_i = '0;
    logic [11:0] ptr2_i = '0;
    logic        ext_en_i = 1'b0;
    logic        full_en_i = 1'b0;
    logic [11:0] full_addr_i = '0;
    logic [11:0] addr_o;
    logic [1:0]  mode_o;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    dag_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .file_i(file_i), .acc_i(acc_i),
        .bsr_i(bsr_i), .ptr2_i(ptr2_i), .ext_en_i(ext_en_i),
        .full_en_i(full_en_i), .full_addr_i(full_addr_i),
        .addr_o(addr_o), .mode_o(mode_o)
    );

    // Reference: returns {mode, addr} as an integer.
    function automatic int model(int f, int a, int b, int p, int x, int fe, int fa);
        if (fe != 0) return (3 << 12) | fa;
        if (a != 0) return (1 << 12) | (b * 256 + f);
        if (x != 0 && f <= 'h5F) return (2 << 12) | ((p + f) % 4096);
        if (f <= 'h5F) return f;
        return 'hF00 + f;
    endfunction

    function automatic string req_of(int f, int a, int x, int fe);
        if (fe != 0) return "R5";
        if (a != 0) return "R1";
        if (x == 0) return "R2";
        if (f <= 'h5F) return "R3";
        return "R4";
    endfunction

    task automatic check_head();
        int e;
        string t;
        int got;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = {18'd0, mode_o, addr_o};
        tests++;
        if (got != e) begin
            fails++;
            $display("FAIL %s/R6: got mode %0d addr %03h, expected mode %0d addr %03h",
                     t, got >> 12, got & 'hFFF, e >> 12, e & 'hFFF);
        end
    endtask

    // Drive one vector at a falling edge, check the previous one first.
    task automatic apply(int f, int a, int b, int p, int x, int fe, int fa);
        @(negedge clk);
        check_head();
        file_i = 8'(f); acc_i = a[0]; bsr_i = 4'(b); ptr2_i = 12'(p);
        ext_en_i = x[0]; full_en_i = fe[0]; full_addr_i = 12'(fa);
        exp_q.push_back(model(f, a, b, p, x, fe, fa));
        tag_q.push_back(req_of(f, a, x, fe));
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        // R7: drive non-zero inputs during reset, expect cleared output.
        file_i = 8'hA5; acc_i = 1'b1; bsr_i = 4'h7; full_en_i = 1'b1; full_addr_i = 12'h9AB;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (addr_o !== 12'h000 || mode_o !== 2'b00) begin
            fails++;
            $display("FAIL R7: got mode %0d addr %03h, expected mode 0 addr 000", mode_o, addr_o);
        end
        rst_n = 1'b1;
        // R1..R4: every file value per access/extended combination.
        for (int a = 0; a < 2; a++)
            for (int x = 0; x < 2; x++)
                for (int f = 0; f < 256; f++)
                    apply(f, a, (f * 7 + a) % 16, (x != 0) ? 'hFC0 + (f % 4) : 'h120,
                          x, 0, 'h555);
        // R3: pointer mid-range and zero.
        for (int f = 0; f < 'h60; f++) apply(f, 0, 3, 'h120, 1, 0, 0);
        apply('h5F, 0, 0, 'h000, 1, 0, 0);
        apply('h60, 0, 0, 'h000, 1, 0, 0);
        // R5: full flag ignores everything else.
        for (int k = 0; k < 64; k++)
            apply((k * 37) % 256, k % 2, k % 16, k * 61 % 4096, (k / 2) % 2, 1,
                  (k * 523 + 17) % 4096);
        // Back to normal after full, to catch stuck selection.
        apply('h10, 0, 0, 'h200, 1, 0, 0);
        apply('h10, 1, 'hE, 'h200, 1, 0, 0);
        @(negedge clk);
        check_head();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule